// File: doc/BRIEF.md
# Eight-Pin I/O Port with Peripheral Override Matrix

This block is one eight-pin general-purpose I/O port. Software sets each pin's direction and output level through a small register bus, and reads the pad levels after a two-flop synchronizer. Writing ones to the pin-read address flips the matching output-level bits. When a pin is an input, its output-level bit switches on a pull-up. A global disable bit turns all such pull-ups off.

Each pin can also be taken over by a peripheral through a set of override pairs. Each pair is an enable and a value, and there is one pair for direction, one for output level and one for pull-up. While an enable is high, its value replaces the setting the registers would give.

Two peripherals use these overrides:
- **External-memory interface (pins 3..0).** These four pins carry a multiplexed address/data bus. The interface drives the pins during its address phase or its write strobe. At all other times it leaves them as inputs with a pull-up that follows the output-level bit. The synchronized pad values go back to the interface as read data, and their input path is never gated off.
- **SPI peripheral (pins 7 and 6).** Pin 7 is the serial clock and pin 6 is the master-in line. The SPI block forces one of these two pins to be an input, depending on whether it runs as master or as slave.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset, the direction register, the output-level register and the pull-up-disable bit are all 0, and pad_oe and pad_pu are 0.
- R2: The bus addresses are as follows. Address 1 reads and writes the direction register, with 1 meaning output. Address 2 reads and writes the output-level register. Bit 0 of address 3 is the global pull-up disable. A write takes effect at the clock edge on which bus_sel and bus_we are high. bus_rdata shows the addressed register combinationally.
- R3: With no override active, a pin whose direction bit is 1 drives its output-level bit on pad_out and has pad_oe high. A pin whose direction bit is 0 has pad_pu equal to its output-level bit AND NOT the pull-up disable.
- R4: A change on pad_in appears on a read of address 0 and on xmem_din exactly two rising clock edges later, and not after one edge.
- R5: A bus write to address 0 inverts every output-level bit whose write-data bit is 1 and leaves the other bits unchanged.
- R6: While xmem_en is high, pins 3..0 drive (pad_oe=1) exactly when xmem_wr or xmem_ale is high. Otherwise they are inputs, whatever their direction bits say.
- R7: While xmem_en is high, pad_out on pin i (i<4) equals (xmem_addr[i] AND xmem_ale) OR (xmem_dout[i] AND xmem_wr).
- R8: While xmem_en is high, pad_pu on pin i (i<4) equals NOT(xmem_wr OR xmem_ale) AND the output-level bit, and the pull-up disable has no effect on it.
- R9: When the SPI is enabled as slave (spi_en=1, spi_master=0), pin 7 is an input whatever its direction bit. As master, pin 7 follows its direction bit.
- R10: When the SPI is enabled as master, pin 6 is an input whatever its direction bit. As slave, pin 6 follows its direction bit.
- R11: A pin forced to input by the SPI has pad_pu equal to its output-level bit AND NOT the pull-up disable. A pin never has pad_pu and pad_oe high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Bus write enable |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad drive enable |
| pad_out | output | 8 | Pad output level |
| pad_pu | output | 8 | Pad pull-up enable |
| spi_en | input | 1 | SPI enabled |
| spi_master | input | 1 | SPI in master mode |
| xmem_en | input | 1 | External-memory interface enabled |
| xmem_wr | input | 1 | External-memory write strobe |
| xmem_ale | input | 1 | External-memory address phase |
| xmem_addr | input | 4 | Address bits for pins 3..0 |
| xmem_dout | input | 4 | Write data bits for pins 3..0 |
| xmem_din | output | 4 | Synchronized read data from pins 3..0 |

## Verification
The hardest case to reach from the ports is a pin where a register setting and an override disagree. Two examples are a direction bit of 1 on a pin the SPI forces to input, and a set pull-up disable on a memory pin whose override ignores it. The vector table first loads direction, output level and the disable bit over the bus. It then applies the peripheral mode, so each row sets up such a conflict before the pad outputs are compared. Synchronizer latency is checked by changing the pads mid-cycle and reading address 0 after one edge and again after two.

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port #(
  parameter int W        = 8,
  parameter int XW       = 4,
  parameter int SCK_PIN  = 7,
  parameter int MISO_PIN = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_pu,
  input  logic          spi_en,
  input  logic          spi_master,
  input  logic          xmem_en,
  input  logic          xmem_wr,
  input  logic          xmem_ale,
  input  logic [XW-1:0] xmem_addr,
  input  logic [XW-1:0] xmem_dout,
  output logic [XW-1:0] xmem_din
);

  logic [W-1:0] dir_q, lvl_q, sync1_q, sync2_q;
  logic         pud_q;
  logic [1:0]   live_q;

  wire wr_en = bus_sel & bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      lvl_q  <= '0;
      pud_q  <= 1'b0;
    end else if (wr_en) begin
      case (bus_addr)
        2'd0: lvl_q <= lvl_q ^ bus_wdata;
        2'd1: dir_q <= bus_wdata;
        2'd2: lvl_q <= bus_wdata;
        default: pud_q <= bus_wdata[0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      live_q  <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      if (live_q != 2'd3) live_q <= live_q + 2'd1;
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = sync2_q;
      2'd1:    bus_rdata = dir_q;
      2'd2:    bus_rdata = lvl_q;
      default: bus_rdata = {{(W-1){1'b0}}, pud_q};
    endcase
  end

  assign xmem_din = sync2_q[XW-1:0];

  wire xbus_act = xmem_wr | xmem_ale;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic ddoe, ddov, pvoe, pvov, puoe, puov;
    if (i < XW) begin : g_xmem
      assign ddoe = xmem_en;
      assign ddov = xbus_act;
      assign pvoe = xmem_en;
      assign pvov = (xmem_addr[i] & xmem_ale) | (xmem_dout[i] & xmem_wr);
      assign puoe = xmem_en;
      assign puov = ~xbus_act & lvl_q[i];
    end else if (i == SCK_PIN) begin : g_sck
      assign ddoe = spi_en & ~spi_master;
      assign ddov = 1'b0;
      assign {pvoe, pvov, puoe, puov} = 4'b0;
    end else if (i == MISO_PIN) begin : g_miso
      assign ddoe = spi_en & spi_master;
      assign ddov = 1'b0;
      assign {pvoe, pvov, puoe, puov} = 4'b0;
    end else begin : g_plain
      assign {ddoe, ddov, pvoe, pvov, puoe, puov} = 6'b0;
    end
    assign pad_oe[i]  = ddoe ? ddov : dir_q[i];
    assign pad_out[i] = pvoe ? pvov : lvl_q[i];
    assign pad_pu[i]  = puoe ? puov : (lvl_q[i] & ~pad_oe[i] & ~pud_q);
  end

  // R5
  pin_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == 2'd0) |=> lvl_q == $past(lvl_q ^ bus_wdata));

  // R4
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q == 2'd3) |-> sync2_q == $past(pad_in, 2));

  // R9
  sck_slave_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && !spi_master) |-> !pad_oe[SCK_PIN]);

  // R10
  miso_master_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && spi_master) |-> !pad_oe[MISO_PIN]);

  // R11
  pu_vs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pu) == '0);

  // R8
  xmem_pu_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xmem_en && xbus_act) |-> pad_pu[XW-1:0] == '0);

endmodule

// File: tb/test_gpio_ovr_port.sv
module test_gpio_ovr_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       bus_sel = 0, bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, pad_in = 0;
  logic [7:0] pad_oe, pad_out, pad_pu;
  logic       spi_en = 0, spi_master = 0, xmem_en = 0, xmem_wr = 0, xmem_ale = 0;
  logic [3:0] xmem_addr = 0, xmem_dout = 0, xmem_din;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ovr_port i_gpio_ovr_port (.*);

  typedef struct packed {
    logic [7:0] dir, lvl;
    logic pud, se, sm, xe, wr, ale;
    logic [3:0] xa, xd;
    logic [7:0] oe, pv, pu;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'hFF,8'hA5,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,4'h0,8'hFF,8'hA5,8'h00,4'd3},  // R3
    '{8'h00,8'h3C,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,4'h0,8'h00,8'h3C,8'h3C,4'd3},  // R3
    '{8'h00,8'h3C,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,4'h0,8'h00,8'h3C,8'h00,4'd3},  // R3
    '{8'hF0,8'hFF,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'h0,4'h0,8'h70,8'hFF,8'h8F,4'd9},  // R9 R11
    '{8'hF0,8'hFF,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,4'h0,4'h0,8'hB0,8'hFF,8'h4F,4'd10}, // R10 R11
    '{8'hF0,8'hFF,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,4'h0,4'h0,8'hF0,8'hFF,8'h0F,4'd10}, // R10
    '{8'h0F,8'h05,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'hA,4'h3,8'h00,8'h00,8'h05,4'd6},  // R6
    '{8'h0F,8'h05,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,4'hA,4'h3,8'h00,8'h00,8'h05,4'd8},  // R8
    '{8'h00,8'hFF,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,4'hA,4'h3,8'h0F,8'hFA,8'hF0,4'd7},  // R7
    '{8'h00,8'h00,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,4'hA,4'h3,8'h0F,8'h03,8'h00,4'd7},  // R7
    '{8'h00,8'h00,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,4'hA,4'h5,8'h0F,8'h0F,8'h00,4'd6},  // R6 R7
    '{8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,4'hA,4'h5,8'h00,8'h00,8'h00,4'd6}   // R6
  };

  task automatic check(input string req, input logic [7:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  initial begin
    logic [7:0] rd;
    #(CLK_PERIOD*3) rst_n = 1;
    @(negedge clk);
    // R1 reset state
    bus_read(2'd1, rd); check("R1 dir", rd, 8'h00);
    bus_read(2'd2, rd); check("R1 lvl", rd, 8'h00);
    bus_read(2'd3, rd); check("R1 pud", rd, 8'h00);
    check("R1 oe", pad_oe, 8'h00);
    check("R1 pu", pad_pu, 8'h00);

    // R2 register readback
    bus_write(2'd1, 8'h5A); bus_read(2'd1, rd); check("R2 dir", rd, 8'h5A);
    bus_write(2'd2, 8'hC3); bus_read(2'd2, rd); check("R2 lvl", rd, 8'hC3);
    bus_write(2'd3, 8'hFF); bus_read(2'd3, rd); check("R2 pud", rd, 8'h01);

    // R5 toggle through address 0
    bus_write(2'd2, 8'h0F);
    bus_write(2'd0, 8'h3C);
    bus_read(2'd2, rd); check("R5 toggle", rd, 8'h33);

    // R4 two-edge synchronizer
    @(negedge clk); pad_in = 8'h96;
    @(negedge clk); bus_read(2'd0, rd); check("R4 one edge", rd, 8'h00);
    @(negedge clk); bus_read(2'd0, rd); check("R4 two edges", rd, 8'h96);
    check("R4 xmem_din", {4'h0, xmem_din}, 8'h06);

    // Vector table
    for (int k = 0; k < NV; k++) begin
      spi_en = 0; spi_master = 0; xmem_en = 0; xmem_wr = 0; xmem_ale = 0;
      bus_write(2'd1, VECS[k].dir);
      bus_write(2'd2, VECS[k].lvl);
      bus_write(2'd3, {7'd0, VECS[k].pud});
      spi_en = VECS[k].se; spi_master = VECS[k].sm;
      xmem_en = VECS[k].xe; xmem_wr = VECS[k].wr; xmem_ale = VECS[k].ale;
      xmem_addr = VECS[k].xa; xmem_dout = VECS[k].xd;
      #1;
      check($sformatf("R%0d vec%0d oe", VECS[k].req, k), pad_oe, VECS[k].oe);
      check($sformatf("R%0d vec%0d out", VECS[k].req, k), pad_out, VECS[k].pv);
      check($sformatf("R%0d vec%0d pu", VECS[k].req, k), pad_pu, VECS[k].pu);
    end

    // R11 forced-input pull-up respects disable
    bus_write(2'd3, 8'h01);
    spi_en = 1; spi_master = 0; xmem_en = 0;
    bus_write(2'd1, 8'hF0); bus_write(2'd2, 8'hFF); #1;
    check("R11 pud on forced pin", pad_pu, 8'h00);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule